// File: doc/BRIEF.md
# Sized ALU with Status Flags

This block is a registered arithmetic and logic unit for an integer execution path. On a strobed request it adds, subtracts, ANDs, ORs or XORs two operands at a width of 8, 16 or 32 bits, chosen per operation. Narrow operations use only the low part of the 32-bit operands.

Along with the result it produces six status flags: unsigned carry/borrow, signed overflow, sign, zero, nibble carry/borrow and parity. The result and flags sit in registers and change only on an accepted operation, so downstream logic can read the flags of the last operation for as long as it needs them. A conditional-branch unit or a flag-merge stage would typically consume them.

Top module: `alu_status_unit`

## Requirements
- R1: With `op_code` 0 (add), `result` is (A + B) modulo 2^w at the selected width w. Result bits at and above w read 0.
- R2: With `op_code` 1 (subtract), `result` is (A − B) modulo 2^w at width w, zero-extended above w.
- R3: `op_code` 2, 3 and 4 give bitwise AND, OR and XOR at width w. They clear the carry, overflow and auxiliary flags.
- R4: Carry is set after an add whose unsigned sum exceeds 2^w − 1. It is set after a subtract when B > A as unsigned values at width w (a borrow).
- R5: Overflow is set after an add or subtract whose two's-complement result lies outside −2^(w−1) … 2^(w−1) − 1.
- R6: Sign equals bit w−1 of the result. Zero is set when the w-bit result is all zeros.
- R7: Auxiliary carry is set after an add when the low nibbles sum to more than 15. It is set after a subtract when the low nibble of A is less than the low nibble of B.
- R8: Parity is set when `result[7:0]` holds an even number of 1 bits, for every width.
- R9: `op_size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the selected width have no effect.
- R10: Result and flags appear on the first rising edge after a cycle with `op_valid` high. They keep their values while `op_valid` is low, whatever the other inputs do.
- R11: `op_code` values 5, 6 and 7 are not operations. A strobe carrying them leaves result and flags unchanged.
- R12: A rising edge with `rst_n` low clears the result and all six flags. Reset takes priority over a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Request strobe, one operation per cycle it is high |
| op_code | input | 3 | Operation: 0 add, 1 sub, 2 and, 3 or, 4 xor |
| op_size | input | 2 | Operand width: 0 byte, 1 halfword, 2/3 word |
| opnd_a | input | 32 | First operand (minuend for subtract) |
| opnd_b | input | 32 | Second operand (subtrahend for subtract) |
| result | output | 32 | Registered result, zero-extended above the width |
| flag_carry | output | 1 | Unsigned carry out or borrow |
| flag_ovf | output | 1 | Signed overflow |
| flag_sign | output | 1 | Top bit of the result at the width |
| flag_zero | output | 1 | Result is zero at the width |
| flag_aux | output | 1 | Carry out of, or borrow into, bit 3 |
| flag_parity | output | 1 | Even number of ones in the low result byte |

## Verification
The properties assume that `op_valid`, `op_code` and `op_size` carry known values at every rising edge after reset. They also assume that `rst_n` is low on the first edge, so that the register state is defined before any hold or stability property is evaluated. The bench keeps to this. It drives `rst_n` low from time zero and changes every input on the falling clock edge only, so the inputs stay settled across each rising edge. It parks the operands at arbitrary values during idle cycles, so the hold properties are tested against moving inputs rather than quiet ones.

// File: rtl/alu_status_pkg.sv
// Package: shared encodings for the sized ALU.
// Assumes a 3-bit operation code; codes past OP_XOR are reserved.
package alu_status_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic parity;
    } alu_flags_t;

    localparam int unsigned NIBBLE_W = 4;
    localparam int unsigned PAR_W    = 8;

endpackage

// File: rtl/alu_size_decode.sv
// Module: turns the size code into a one-hot lane select.
// Assumes lane i is BASE_W << i bits wide. Codes at or past the widest lane
// select the widest lane.
module alu_size_decode #(
    parameter int unsigned LANES = 3,
    parameter int unsigned SZ_W  = 2
) (
    input  logic [SZ_W-1:0]  size_code,
    output logic [LANES-1:0] lane_sel
);

    // Purpose: one-hot decode with saturation to the widest lane.
    always_comb begin
        lane_sel = '0;
        if (int'(size_code) >= LANES - 1)
            lane_sel[LANES-1] = 1'b1;
        else
            lane_sel[size_code] = 1'b1;
    end

endmodule

// File: rtl/alu_addsub.sv
// Module: full-width adder/subtractor that also exposes the carry into every bit.
// Subtract is A + ~B + 1. carry_vec[k] is the carry into bit k, and
// carry_vec[DATA_W] is the final carry out. A narrow lane reads its own
// carry out from carry_vec at its width.
module alu_addsub #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W:0]   carry_vec
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   total;

    // Purpose: invert B for subtract and form the wide sum.
    always_comb begin
        b_eff = sub ? ~b : b;
        total = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    end

    assign sum                     = total[DATA_W-1:0];
    assign carry_vec[DATA_W-1:0]   = a ^ b_eff ^ total[DATA_W-1:0];
    assign carry_vec[DATA_W]       = total[DATA_W];

endmodule

// File: rtl/alu_flag_gen.sv
// Module: masks the raw result to the selected lane and derives six status flags.
// Assumes lane_sel is one-hot. For subtract, a carry of 0 means a borrow, so
// the carry and auxiliary flags invert. Logic operations clear carry,
// overflow and auxiliary.
module alu_flag_gen
    import alu_status_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BASE_W = 8,
    parameter int unsigned LANES  = 3
) (
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] raw_res,
    input  logic [DATA_W:0]   carry_vec,
    input  logic              is_arith,
    input  logic              is_sub,
    output logic [DATA_W-1:0] res_out,
    output alu_flags_t        flags_out
);

    logic [LANES-1:0]  l_cout;
    logic [LANES-1:0]  l_cmsb;
    logic [LANES-1:0]  l_sign;
    logic [DATA_W-1:0] l_mask [LANES];

    // Per-lane taps: carry out, carry into the top bit, top bit, width mask.
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int unsigned LW = BASE_W << gi;
        assign l_cout[gi] = carry_vec[LW];
        assign l_cmsb[gi] = carry_vec[LW-1];
        assign l_sign[gi] = raw_res[LW-1];
        assign l_mask[gi] = {DATA_W{1'b1}} >> (DATA_W - LW);
    end

    logic [DATA_W-1:0] sel_mask;
    logic              sel_cout;
    logic              sel_cmsb;
    logic              sel_sign;

    // Purpose: pick the taps of the active lane.
    always_comb begin
        sel_mask = '0;
        sel_cout = 1'b0;
        sel_cmsb = 1'b0;
        sel_sign = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_sel[i]) begin
                sel_mask = sel_mask | l_mask[i];
                sel_cout = sel_cout | l_cout[i];
                sel_cmsb = sel_cmsb | l_cmsb[i];
                sel_sign = sel_sign | l_sign[i];
            end
        end
    end

    // Purpose: form the masked result and the flag set.
    always_comb begin
        res_out          = raw_res & sel_mask;
        flags_out.carry  = is_arith & (sel_cout ^ is_sub);
        flags_out.ovf    = is_arith & (sel_cout ^ sel_cmsb);
        flags_out.aux    = is_arith & (carry_vec[NIBBLE_W] ^ is_sub);
        flags_out.sign   = sel_sign;
        flags_out.zero   = (res_out == '0);
        flags_out.parity = ~^res_out[PAR_W-1:0];
    end

endmodule

// File: rtl/alu_status_unit.sv
// Module: top of the sized ALU. It registers the result and the six flags on
// each strobe that carries a known operation code.
// Assumes a synchronous active-low reset that overrides the strobe. The
// outputs hold while no operation is accepted.
module alu_status_unit
    import alu_status_pkg::*;
#(
    parameter int unsigned BASE_W = 8,
    parameter int unsigned LANES  = 3,
    parameter int unsigned SZ_W   = 2,
    parameter int unsigned OP_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             op_valid,
    input  logic [OP_W-1:0]                  op_code,
    input  logic [SZ_W-1:0]                  op_size,
    input  logic [(BASE_W<<(LANES-1))-1:0]   opnd_a,
    input  logic [(BASE_W<<(LANES-1))-1:0]   opnd_b,
    output logic [(BASE_W<<(LANES-1))-1:0]   result,
    output logic                             flag_carry,
    output logic                             flag_ovf,
    output logic                             flag_sign,
    output logic                             flag_zero,
    output logic                             flag_aux,
    output logic                             flag_parity
);

    localparam int unsigned DATA_W = BASE_W << (LANES - 1);

    logic [LANES-1:0]  lane_sel;
    logic [DATA_W-1:0] sum;
    logic [DATA_W:0]   carry_vec;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] raw_res;
    logic [DATA_W-1:0] next_res;
    alu_flags_t        next_flags;
    logic              is_arith;
    logic              is_sub;
    logic              op_known;

    logic [DATA_W-1:0] res_q;
    alu_flags_t        flags_q;

    alu_size_decode #(.LANES(LANES), .SZ_W(SZ_W)) u_size (
        .size_code (op_size),
        .lane_sel  (lane_sel)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (is_sub),
        .sum       (sum),
        .carry_vec (carry_vec)
    );

    // Purpose: classify the operation code.
    always_comb begin
        is_sub   = (op_code == OP_SUB);
        is_arith = (op_code == OP_ADD) || is_sub;
        op_known = (op_code <= OP_XOR);
    end

    // Purpose: bitwise operations, then the choice of arithmetic or logic result.
    always_comb begin
        unique case (op_code)
            OP_AND:  logic_res = opnd_a & opnd_b;
            OP_OR:   logic_res = opnd_a | opnd_b;
            OP_XOR:  logic_res = opnd_a ^ opnd_b;
            default: logic_res = '0;
        endcase
        raw_res = is_arith ? sum : logic_res;
    end

    alu_flag_gen #(.DATA_W(DATA_W), .BASE_W(BASE_W), .LANES(LANES)) u_flags (
        .lane_sel  (lane_sel),
        .raw_res   (raw_res),
        .carry_vec (carry_vec),
        .is_arith  (is_arith),
        .is_sub    (is_sub),
        .res_out   (next_res),
        .flags_out (next_flags)
    );

    // Purpose: output registers, loaded on an accepted operation, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (op_valid && op_known) begin
            res_q   <= next_res;
            flags_q <= next_flags;
        end
    end

    assign result      = res_q;
    assign flag_carry  = flags_q.carry;
    assign flag_ovf    = flags_q.ovf;
    assign flag_sign   = flags_q.sign;
    assign flag_zero   = flags_q.zero;
    assign flag_aux    = flags_q.aux;
    assign flag_parity = flags_q.parity;

endmodule

// File: rtl/alu_status_sva.sv
// Module: property checker for alu_status_unit, attached by bind.
// Assumes the strobe, code and size are known at every edge after reset.
module alu_status_sva #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BASE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [1:0]        op_size,
    input logic [DATA_W-1:0] result,
    input logic              flag_carry,
    input logic              flag_ovf,
    input logic              flag_sign,
    input logic              flag_zero,
    input logic              flag_aux,
    input logic              flag_parity
);

    logic [5:0] flag_vec;
    assign flag_vec = {flag_carry, flag_ovf, flag_sign, flag_zero, flag_aux, flag_parity};

    assert_reset_clears_R12: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && flag_vec == '0));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(result) && $stable(flag_vec)));

    assert_reserved_no_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > 3'd4) |=> ($stable(result) && $stable(flag_vec)));

    assert_logic_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 3'd2 && op_code <= 3'd4) |=> (!flag_carry && !flag_ovf && !flag_aux));

    assert_parity_low_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 3'd4) |=> (flag_parity == ~^result[7:0]));

    assert_zero_matches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 3'd4) |=> (flag_zero == (result == '0)));

    assert_byte_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 3'd4 && op_size == 2'd0) |=> (result[DATA_W-1:BASE_W] == '0));

endmodule

bind alu_status_unit alu_status_sva #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .op_size     (op_size),
    .result      (result),
    .flag_carry  (flag_carry),
    .flag_ovf    (flag_ovf),
    .flag_sign   (flag_sign),
    .flag_zero   (flag_zero),
    .flag_aux    (flag_aux),
    .flag_parity (flag_parity)
);

// File: tb/tb_alu_status_unit.sv
// Bench: directed tests of alu_status_unit, one task per scenario.
// Expected values come from an arithmetic model of the requirements.
module tb_alu_status_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [1:0]  op_size = 2'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        flag_carry, flag_ovf, flag_sign, flag_zero, flag_aux, flag_parity;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_res = '0;
    logic [5:0]  exp_flags = '0;

    always #2 clk = ~clk;

    alu_status_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_sign(flag_sign),
        .flag_zero(flag_zero), .flag_aux(flag_aux), .flag_parity(flag_parity)
    );

    // Model: computes the expected result and flags {C,O,S,Z,A,P} from the requirements.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input int op,
                         input int sz, output logic [31:0] r, output logic [5:0] f);
        longint w, mask, am, bm, sa, sb, full, sr, lo, hi;
        logic c, o, ac;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask = (longint'(1) << w) - 1;
        am = longint'(a) & mask;
        bm = longint'(b) & mask;
        sa = (am >= (longint'(1) << (w - 1))) ? am - (longint'(1) << w) : am;
        sb = (bm >= (longint'(1) << (w - 1))) ? bm - (longint'(1) << w) : bm;
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
        c = 1'b0; o = 1'b0; ac = 1'b0; full = 0;
        case (op)
            0: begin full = am + bm; c = full > mask; sr = sa + sb;
                     o = (sr > hi) || (sr < lo); ac = ((am & 15) + (bm & 15)) > 15; end
            1: begin full = am - bm; c = am < bm; sr = sa - sb;
                     o = (sr > hi) || (sr < lo); ac = (am & 15) < (bm & 15); end
            2: full = am & bm;
            3: full = am | bm;
            default: full = am ^ bm;
        endcase
        full = full & mask;
        r = full[31:0];
        f = {c, o, full[w-1], full == 0, ac, ~^full[7:0]};
    endtask

    // Compares the outputs with the expected state and counts one check.
    task automatic check(input string req);
        logic [5:0] act;
        act = {flag_carry, flag_ovf, flag_sign, flag_zero, flag_aux, flag_parity};
        checks++;
        if (result !== exp_res || act !== exp_flags) begin
            errors++;
            $display("FAIL %s: result=%h flags(COSZAP)=%b expected result=%h flags=%b",
                     req, result, act, exp_res, exp_flags);
        end
    endtask

    // Drives one strobed operation at a falling edge and checks it one edge later.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int op,
                          input int sz, input string req);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_code = 3'(op); op_size = 2'(sz); op_valid = 1'b1;
        if (op <= 4) model(a, b, op, sz, exp_res, exp_flags);
        @(negedge clk);
        op_valid = 1'b0;
        check(req);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        exp_res = '0; exp_flags = '0;
        check("R12 initial");
    endtask

    task automatic t_add();
        run_op(32'h0000_00FF, 32'h0000_0001, 0, 0, "R1 R4 R7 byte wrap to zero");
        run_op(32'h0000_007F, 32'h0000_0001, 0, 0, "R5 R6 byte signed overflow");
        run_op(32'h0000_8000, 32'h0000_8000, 0, 1, "R4 R5 halfword carry and overflow");
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 0, 2, "R1 R4 word carry out");
        run_op(32'h1234_0008, 32'h0000_0008, 0, 2, "R7 word nibble carry");
    endtask

    task automatic t_sub();
        run_op(32'h0000_0000, 32'h0000_0001, 1, 0, "R2 R4 R7 byte borrow");
        run_op(32'h0000_0080, 32'h0000_0001, 1, 0, "R5 byte signed overflow on subtract");
        run_op(32'h0000_0005, 32'h0000_0005, 1, 2, "R2 R6 word zero");
        run_op(32'h0000_1000, 32'h0000_0001, 1, 1, "R7 halfword nibble borrow");
    endtask

    task automatic t_logic();
        run_op(32'h0000_00FF, 32'h0000_0001, 0, 0, "R3 setup carry");
        run_op(32'hFFFF_F0F0, 32'h0000_0FF0, 2, 1, "R3 halfword AND clears carry");
        run_op(32'h8000_0000, 32'h0000_0001, 3, 2, "R3 R6 word OR sign");
        run_op(32'h0000_00AA, 32'h0000_00AA, 4, 0, "R3 R6 byte XOR zero");
    endtask

    task automatic t_sizes();
        run_op(32'h1234_56FF, 32'hABCD_EF01, 0, 0, "R9 upper operand bits ignored");
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 0, 3, "R9 size code 3 acts as word");
        run_op(32'h0001_FFFF, 32'h0000_0001, 0, 1, "R9 halfword wrap");
    endtask

    task automatic t_parity();
        run_op(32'h0100_0003, 32'h0000_0000, 3, 2, "R8 parity from low byte only");
        run_op(32'h0000_0107, 32'h0000_0000, 3, 1, "R8 odd low byte");
    endtask

    task automatic t_hold();
        run_op(32'h0000_0042, 32'h0000_0013, 0, 0, "R10 operation lands next edge");
        @(negedge clk);
        opnd_a = 32'hDEAD_BEEF; opnd_b = 32'h0BAD_F00D; op_code = 3'd1; op_size = 2'd2;
        repeat (3) @(negedge clk);
        check("R10 hold while idle");
    endtask

    task automatic t_reserved();
        run_op(32'h0000_0003, 32'h0000_0004, 0, 0, "R11 setup");
        run_op(32'h0000_0000, 32'h0000_0000, 5, 2, "R11 code 5 ignored");
        run_op(32'hFFFF_FFFF, 32'h0000_0001, 7, 0, "R11 code 7 ignored");
    endtask

    task automatic t_reset_mid();
        run_op(32'h0000_00F0, 32'h0000_0080, 0, 0, "R12 setup");
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b1; op_code = 3'd0; opnd_a = 32'h7F; opnd_b = 32'h1;
        @(negedge clk);
        op_valid = 1'b0; rst_n = 1'b1;
        exp_res = '0; exp_flags = '0;
        check("R12 reset beats strobe");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_logic();
        t_sizes();
        t_parity();
        t_hold();
        t_reserved();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule